// File: doc/BRIEF.md
# Cascadable Display Column Data Sampler

This block is the digital front end of a column driver for an active-matrix panel. On every clock it takes six 8-bit colour codes, which are two RGB pixels. A start pulse on the incoming cascade pin arms a sequencer. Over the following 64 clocks the sequencer writes a 384-entry line latch. The latch fills from the first column upward, or from the last column downward, depending on a direction control. When the 64th beat has been captured, a one-clock finish pulse leaves on the outgoing cascade pin, so the next device in a daisy chain can take over.

A load strobe moves the whole line latch into an output holding register and captures a polarity flag at the same moment. The flag tells the analog stage, for every column, whether that column uses the positive or the negative half of the voltage range, giving dot inversion. Two invert controls can complement the incoming codes of either half of the lanes. The load strobe is synchronised to the clock, and only its rising edge has an effect. Gamma references, DACs and output amplifiers belong to the analog stage and are not part of this block.

Top module: `line_sampler`

## Requirements
- R1: After a synchronous active-low reset, every held code is 0x00, the captured polarity flag is 0, both cascade outputs are 0 and no fill is in progress.
- R2: When `inv_lo` is high, lanes 0..2 are stored bitwise complemented (0x07 is stored as 0xF8). `inv_hi` does the same for lanes 3..5. Each control affects only its own three lanes.
- R3: With `dir_fwd`=1, a rising level on `cas_a_in` at a clock edge starts a fill. On the k-th following edge (k=1..64) lane L is written to column index (k-1)*6+L, where index 0 is column 1.
- R4: With `dir_fwd`=0 the start is taken from `cas_b_in` and the finish pulse is sent on `cas_a_out`. Lane L of beat k is written to column index 383-((k-1)*6+L).
- R5: The finish pulse is high for exactly one clock, starting at the edge that captures beat 64. It appears only on the outgoing pin, and the other cascade output stays 0.
- R6: The fill stops by itself after 64 captures, and later data changes leave the line latch unchanged. A start level held high over many clocks starts only one fill and gives one finish pulse.
- R7: A new rising start level during a fill restarts the fill. That edge captures nothing, and the following edge writes beat 1 again. The interrupted fill emits no finish pulse.
- R8: The clock edge at which `load` is first seen high copies the line latch into `col_code`, even when the line is only partly written.
- R9: The load edge also captures `pol_in`. Column numbers start at 1, and `col_pos` bit i belongs to column i+1. When the captured flag is 1, even columns (odd i) have `col_pos`=1 and odd columns have `col_pos`=0. When the flag is 0 the pattern is reversed.
- R10: `col_code` and `col_pos` change only at a load edge. If a load edge falls on the same edge as a capture, the held line is the content from before that capture.
- R11: `cas_b_oe` equals `dir_fwd` and `cas_a_oe` is its complement, so only the outgoing pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action happens on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | 1: enter on pin A, fill upward; 0: enter on pin B, fill downward |
| inv_lo | input | 1 | Complement lanes 0..2 |
| inv_hi | input | 1 | Complement lanes 3..5 |
| lane_data | input | 48 | Six 8-bit codes; lane L in bits L*8+7..L*8 |
| cas_a_in | input | 1 | Cascade pin A, incoming level |
| cas_b_in | input | 1 | Cascade pin B, incoming level |
| cas_a_out | output | 1 | Cascade pin A, outgoing finish pulse |
| cas_a_oe | output | 1 | Drive enable for pin A |
| cas_b_out | output | 1 | Cascade pin B, outgoing finish pulse |
| cas_b_oe | output | 1 | Drive enable for pin B |
| load | input | 1 | Load strobe, active on its rising level |
| pol_in | input | 1 | Polarity flag captured at the load edge |
| col_code | output | 3072 | 384 held codes; column index i in bits i*8+7..i*8 |
| col_pos | output | 384 | Per-column positive-half flag |

## Verification
The load edge and a capture can fall on the same clock edge. The most telling case is the edge that captures the last beat, because there the finish pulse also rises. The bench provokes this by raising `load` in the half cycle in which it presents the 64th beat. It then checks three things: the finish pulse is present, the held line has every column except the six written by beat 64, and a second load afterwards brings those six in. A load during a partial fill, with capture still running, checks the same ordering in the middle of a line.

// File: rtl/line_pkg.sv
package line_pkg;

   typedef enum logic {FILL_DOWN = 1'b0, FILL_UP = 1'b1} fill_dir_e;

   // Column index written by a lane on a given beat (beat counted from 0).
   function automatic int col_of(input int beat, input int lane, input logic up,
                                 input int lanes, input int cols);
      int linear;
      linear = beat * lanes + lane;
      return (fill_dir_e'(up) == FILL_UP) ? linear : (cols - 1 - linear);
   endfunction

endpackage

// File: rtl/lane_invert.sv
module lane_invert #(
   parameter int LANES  = 6,
   parameter int CODE_W = 8,
   parameter int SPLIT  = 3
) (
   input  logic [LANES*CODE_W-1:0] din,
   input  logic                    inv_lo,
   input  logic                    inv_hi,
   output logic [LANES*CODE_W-1:0] dout
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g < SPLIT) begin : g_low
         assign dout[g*CODE_W +: CODE_W] = din[g*CODE_W +: CODE_W] ^ {CODE_W{inv_lo}};
      end else begin : g_high
         assign dout[g*CODE_W +: CODE_W] = din[g*CODE_W +: CODE_W] ^ {CODE_W{inv_hi}};
      end
   end

endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
   parameter int BEATS  = 64,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_lvl,
   output logic              busy,
   output logic [BEAT_W-1:0] beat,
   output logic              capture,
   output logic              done
);

   logic start_q;
   logic start_rise;

   assign start_rise = start_lvl & ~start_q;
   assign capture    = busy & ~start_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy    <= 1'b0;
         beat    <= '0;
         done    <= 1'b0;
      end else begin
         start_q <= start_lvl;
         done    <= 1'b0;
         if (start_rise) begin
            busy <= 1'b1;
            beat <= '0;
         end else if (busy) begin
            if (beat == BEAT_W'(BEATS - 1)) begin
               busy <= 1'b0;
               beat <= '0;
               done <= 1'b1;
            end else begin
               beat <= beat + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/edge_sync.sv
module edge_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);

   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/hold_stage.sv
module hold_stage #(
   parameter int COLS   = 384,
   parameter int CODE_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   take,
   input  logic                   pol_in,
   input  logic [COLS*CODE_W-1:0] line_in,
   output logic [COLS*CODE_W-1:0] col_code,
   output logic [COLS-1:0]        col_pos
);

   logic                   pol_q;
   logic [COLS*CODE_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         pol_q  <= 1'b0;
      end else if (take) begin
         hold_q <= line_in;
         pol_q  <= pol_in;
      end
   end

   assign col_code = hold_q;

   // Index i is column i+1: odd i are the even-numbered columns.
   for (genvar i = 0; i < COLS; i++) begin : g_pol
      if (i % 2 == 1) begin : g_even_col
         assign col_pos[i] = pol_q;
      end else begin : g_odd_col
         assign col_pos[i] = ~pol_q;
      end
   end

endmodule

// File: rtl/line_sampler.sv
module line_sampler
   import line_pkg::*;
#(
   parameter int  LANES     = 6,
   parameter int  CODE_W    = 8,
   parameter int  BEATS     = 64,
   parameter int  INV_SPLIT = 3,
   localparam int COLS      = LANES * BEATS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dir_fwd,
   input  logic                    inv_lo,
   input  logic                    inv_hi,
   input  logic [LANES*CODE_W-1:0] lane_data,
   input  logic                    cas_a_in,
   input  logic                    cas_b_in,
   output logic                    cas_a_out,
   output logic                    cas_a_oe,
   output logic                    cas_b_out,
   output logic                    cas_b_oe,
   input  logic                    load,
   input  logic                    pol_in,
   output logic [COLS*CODE_W-1:0]  col_code,
   output logic [COLS-1:0]         col_pos
);

   localparam int BEAT_W = $clog2(BEATS);

   if (LANES < 2 || (LANES % 2) != 0) begin : g_chk_lanes
      $error("line_sampler: LANES must be even and at least 2");
   end
   if (CODE_W < 1) begin : g_chk_width
      $error("line_sampler: CODE_W must be positive");
   end
   if (BEATS < 2) begin : g_chk_beats
      $error("line_sampler: BEATS must be at least 2");
   end
   if (INV_SPLIT < 0 || INV_SPLIT > LANES) begin : g_chk_split
      $error("line_sampler: INV_SPLIT must lie within 0..LANES");
   end

   logic                    start_lvl;
   logic                    fill_busy;
   logic [BEAT_W-1:0]       fill_beat;
   logic                    capture;
   logic                    fill_done;
   logic                    load_take;
   logic [LANES*CODE_W-1:0] lane_fix;
   logic [COLS*CODE_W-1:0]  line_q;

   assign start_lvl = dir_fwd ? cas_a_in : cas_b_in;

   fill_seq #(.BEATS(BEATS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_lvl (start_lvl),
      .busy      (fill_busy),
      .beat      (fill_beat),
      .capture   (capture),
      .done      (fill_done)
   );

   lane_invert #(.LANES(LANES), .CODE_W(CODE_W), .SPLIT(INV_SPLIT)) u_inv (
      .din    (lane_data),
      .inv_lo (inv_lo),
      .inv_hi (inv_hi),
      .dout   (lane_fix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
      end else if (capture) begin
         for (int l = 0; l < LANES; l++) begin
            line_q[col_of(int'(fill_beat), l, dir_fwd, LANES, COLS)*CODE_W +: CODE_W]
               <= lane_fix[l*CODE_W +: CODE_W];
         end
      end
   end

   edge_sync u_load (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (load),
      .rise  (load_take)
   );

   hold_stage #(.COLS(COLS), .CODE_W(CODE_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (load_take),
      .pol_in   (pol_in),
      .line_in  (line_q),
      .col_code (col_code),
      .col_pos  (col_pos)
   );

   assign cas_b_oe  = dir_fwd;
   assign cas_a_oe  = ~dir_fwd;
   assign cas_b_out = fill_done & dir_fwd;
   assign cas_a_out = fill_done & ~dir_fwd;

endmodule

// File: rtl/line_sampler_chk.sv
module line_sampler_chk #(
   parameter int COLS   = 384,
   parameter int CODE_W = 8,
   parameter int BEATS  = 64,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dir_fwd,
   input logic                   cas_a_in,
   input logic                   cas_b_in,
   input logic                   cas_a_out,
   input logic                   cas_a_oe,
   input logic                   cas_b_out,
   input logic                   cas_b_oe,
   input logic                   load,
   input logic [COLS*CODE_W-1:0] col_code,
   input logic [COLS-1:0]        col_pos,
   input logic                   fill_busy,
   input logic [BEAT_W-1:0]      fill_beat
);

   logic ld_q;
   logic st_q;
   logic st_now;

   assign st_now = dir_fwd ? cas_a_in : cas_b_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_q <= 1'b0;
         st_q <= 1'b0;
      end else begin
         ld_q <= load;
         st_q <= st_now;
      end
   end

   assert_a_out_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cas_a_out |-> cas_a_oe);

   assert_b_out_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cas_b_out |-> cas_b_oe);

   assert_finish_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_a_out || cas_b_out) |=> !(cas_a_out || cas_b_out));

   assert_finish_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_a_out || cas_b_out) |-> ($past(fill_busy) && $past(fill_beat) == BEAT_W'(BEATS - 1)));

   assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_now && !st_q) |=> (fill_busy && fill_beat == '0));

   assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && !ld_q) |=> ($stable(col_code) && $stable(col_pos)));

   assert_pol_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      col_pos[0] != col_pos[1]);

endmodule

bind line_sampler line_sampler_chk #(.COLS(COLS), .CODE_W(CODE_W), .BEATS(BEATS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir_fwd   (dir_fwd),
   .cas_a_in  (cas_a_in),
   .cas_b_in  (cas_b_in),
   .cas_a_out (cas_a_out),
   .cas_a_oe  (cas_a_oe),
   .cas_b_out (cas_b_out),
   .cas_b_oe  (cas_b_oe),
   .load      (load),
   .col_code  (col_code),
   .col_pos   (col_pos),
   .fill_busy (fill_busy),
   .fill_beat (fill_beat)
);

// File: tb/test_line_sampler.sv
module test_line_sampler;

   localparam int LANES  = 6;
   localparam int CODE_W = 8;
   localparam int BEATS  = 64;
   localparam int COLS   = LANES * BEATS;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    dir_fwd;
   logic                    inv_lo;
   logic                    inv_hi;
   logic [LANES*CODE_W-1:0] lane_data;
   logic                    cas_a_in;
   logic                    cas_b_in;
   logic                    cas_a_out;
   logic                    cas_a_oe;
   logic                    cas_b_out;
   logic                    cas_b_oe;
   logic                    load;
   logic                    pol_in;
   logic [COLS*CODE_W-1:0]  col_code;
   logic [COLS-1:0]         col_pos;

   logic [7:0] exp_line [COLS];
   logic [7:0] exp_hold [COLS];
   logic       exp_pol;
   int         n_chk = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   line_sampler i_line_sampler (
      .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .inv_lo(inv_lo), .inv_hi(inv_hi),
      .lane_data(lane_data), .cas_a_in(cas_a_in), .cas_b_in(cas_b_in),
      .cas_a_out(cas_a_out), .cas_a_oe(cas_a_oe), .cas_b_out(cas_b_out), .cas_b_oe(cas_b_oe),
      .load(load), .pol_in(pol_in), .col_code(col_code), .col_pos(col_pos)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] gen(input int seed, input int b, input int l);
      return 8'((seed * 53 + b * 11 + l * 29 + b * l) & 255);
   endfunction

   task automatic set_beat(input int seed, input int b);
      for (int l = 0; l < LANES; l++) begin
         logic [7:0] v;
         int base;
         v = gen(seed, b, l);
         if ((l < 3 && inv_lo) || (l >= 3 && inv_hi)) v = ~v;
         lane_data[l*8 +: 8] = gen(seed, b, l);
         base = b * LANES + l;
         exp_line[dir_fwd ? base : COLS - 1 - base] = v;
      end
   endtask

   task automatic start_pulse();
      @(negedge clk);
      if (dir_fwd) cas_a_in = 1'b1;
      else         cas_b_in = 1'b1;
      lane_data = {$urandom, $urandom};
   endtask

   task automatic fill(input int seed, input int n, input int width);
      for (int b = 0; b < n; b++) begin
         @(negedge clk);
         if (b >= width - 1) begin
            cas_a_in = 1'b0;
            cas_b_in = 1'b0;
         end
         set_beat(seed, b);
      end
   endtask

   task automatic check_finish(input string tag);
      @(negedge clk);
      check((dir_fwd ? cas_b_out : cas_a_out) == 1'b1, {tag, " finish pulse"},
            dir_fwd ? cas_b_out : cas_a_out, 1);
      check((dir_fwd ? cas_a_out : cas_b_out) == 1'b0, {tag, " incoming pin quiet"},
            dir_fwd ? cas_a_out : cas_b_out, 0);
      @(negedge clk);
      check(!cas_a_out && !cas_b_out, {tag, " finish one clock"}, {cas_a_out, cas_b_out}, 0);
   endtask

   task automatic pulse_load(input logic p);
      @(negedge clk);
      load = 1'b1;
      pol_in = p;
      exp_hold = exp_line;
      exp_pol = p;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic check_hold(input string tag);
      int bad_i;
      int bad_p;
      bad_i = -1;
      bad_p = -1;
      for (int i = COLS - 1; i >= 0; i--) begin
         if (col_code[i*8 +: 8] !== exp_hold[i]) bad_i = i;
         if (col_pos[i] !== ((i % 2 == 1) ? exp_pol : ~exp_pol)) bad_p = i;
      end
      if (bad_i < 0) check(1'b1, {tag, " codes"}, 0, 0);
      else check(1'b0, $sformatf("%s codes col index %0d", tag, bad_i),
                 col_code[bad_i*8 +: 8], exp_hold[bad_i]);
      if (bad_p < 0) check(1'b1, {tag, " polarity"}, 0, 0);
      else check(1'b0, $sformatf("%s polarity col index %0d", tag, bad_p),
                 col_pos[bad_p], (bad_p % 2 == 1) ? exp_pol : ~exp_pol);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      dir_fwd = 1'b1; inv_lo = 1'b0; inv_hi = 1'b0;
      cas_a_in = 1'b0; cas_b_in = 1'b0; load = 1'b0; pol_in = 1'b0;
      lane_data = '0;
      for (int i = 0; i < COLS; i++) begin exp_line[i] = 8'h00; exp_hold[i] = 8'h00; end
      exp_pol = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_hold("R1 reset");
      check(!cas_a_out && !cas_b_out, "R1 cascade outputs", {cas_a_out, cas_b_out}, 0);
      check(cas_b_oe && !cas_a_oe, "R11 enables forward", {cas_a_oe, cas_b_oe}, 1);
   endtask

   task automatic t_forward();
      dir_fwd = 1'b1; inv_lo = 1'b0; inv_hi = 1'b0;
      start_pulse();
      fill(1, BEATS, 1);
      check_finish("R3 R5 forward");
      check_hold("R10 no load, hold unchanged");
      pulse_load(1'b1);
      check_hold("R3 R8 forward line");
   endtask

   task automatic t_reverse();
      dir_fwd = 1'b0; inv_lo = 1'b1; inv_hi = 1'b0;
      @(negedge clk);
      check(cas_a_oe && !cas_b_oe, "R11 enables reverse", {cas_a_oe, cas_b_oe}, 2);
      start_pulse();
      fill(2, BEATS, 1);
      check_finish("R4 R5 reverse");
      pulse_load(1'b0);
      check_hold("R4 R2 reverse with low invert");
   endtask

   task automatic t_invert_hi();
      dir_fwd = 1'b1; inv_lo = 1'b0; inv_hi = 1'b1;
      start_pulse();
      fill(3, BEATS - 1, 1);
      @(negedge clk);
      lane_data = {8'h15, 8'h07, 8'h07, 8'h15, 8'h07, 8'h07};
      for (int l = 0; l < LANES; l++) exp_line[(BEATS - 1) * LANES + l] = 8'hxx;
      exp_line[378] = 8'h07; exp_line[379] = 8'h07; exp_line[380] = 8'h15;
      exp_line[381] = 8'hF8; exp_line[382] = 8'hF8; exp_line[383] = 8'hEA;
      check_finish("R2 R5 high invert");
      pulse_load(1'b1);
      check_hold("R2 high invert only lanes 3..5");
      inv_hi = 1'b0;
   endtask

   task automatic t_wide_start();
      int extra;
      dir_fwd = 1'b1;
      start_pulse();
      fill(4, BEATS, 1000);
      check_finish("R6 wide start");
      extra = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         lane_data = {$urandom, $urandom};
         if (cas_a_out || cas_b_out) extra++;
      end
      cas_a_in = 1'b0;
      check(extra == 0, "R6 one finish for held start", extra, 0);
      pulse_load(1'b0);
      check_hold("R6 data after self-stop ignored");
   endtask

   task automatic t_partial_restart();
      int seen;
      dir_fwd = 1'b0;
      start_pulse();
      fill(5, 10, 1);
      pulse_load(1'b1);
      check_hold("R8 partial line load");
      start_pulse();
      fill(6, BEATS, 2);
      check_finish("R7 restarted fill");
      pulse_load(1'b0);
      check_hold("R7 restart writes from first beat");
      seen = 0;
      for (int c = 0; c < 80; c++) begin
         @(negedge clk);
         if (cas_a_out || cas_b_out) seen++;
      end
      check(seen == 0, "R7 interrupted fill silent", seen, 0);
   endtask

   task automatic t_coincide();
      dir_fwd = 1'b1;
      start_pulse();
      fill(9, BEATS - 1, 1);
      @(negedge clk);
      exp_hold = exp_line;
      exp_pol = 1'b1;
      set_beat(9, BEATS - 1);
      load = 1'b1;
      pol_in = 1'b1;
      @(negedge clk);
      load = 1'b0;
      check(cas_b_out == 1'b1, "R10 finish with coincident load", cas_b_out, 1);
      check_hold("R10 coincident load excludes last beat");
      pulse_load(1'b1);
      check_hold("R10 later load includes last beat");
   endtask

   task automatic t_polarity();
      pulse_load(1'b0);
      check_hold("R9 polarity 0");
      pulse_load(1'b1);
      check_hold("R9 polarity 1");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_forward();
      t_reverse();
      t_invert_hi();
      t_wide_start();
      t_partial_restart();
      t_coincide();
      t_polarity();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule